// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers one non-maskable request, seven ordinary interrupt lines and a 16-bit software flag register. It presents a single request, with the number of the winning source, to a processor core. Each ordinary line has its own 3-bit priority and its own detection mode. In edge mode a rising edge is latched until software clears it. In level mode the request follows the wire.

The flag register counts as an eighth ordinary source, number 7, with its own priority. A control bit sends its request either into the core arbitration or out on a separate pin for an external device. A programmable level mask suppresses weak requests. The non-maskable input overrides everything.

Software reaches the block through a simple synchronous register port. Writes take effect on the clock edge and reads are combinational. The winner is registered, so the core sees a change one clock after the pending state changes.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all registers read 0, `core_req_o` and `ext_flag_o` are 0 and `core_src_o` is 0.
- R2: While `nmi_i` is high, `core_req_o` is 1 and `core_src_o` is 8 one clock later. The level mask and the priorities do not affect this.
- R3: A line in level mode (bit n of address 2 equal to 0) shows pending bit n equal to the line. Writing 1 to that bit at address 3 does not clear it.
- R4: A line in edge mode (bit n of address 2 equal to 1) sets pending bit n on a rising edge and holds it after the line falls. Writing 0 to it at address 3 leaves it set. Writing 1 clears it.
- R5: A source whose priority is 0 never wins.
- R6: Among pending sources the highest priority wins. If priorities are equal, the lower source number wins.
- R7: `core_req_o` rises only when the winning priority is strictly greater than the mask in bits [2:0] of address 5 (or `nmi_i` is high).
- R8: Address 4 is a read/write flag register. While it is nonzero and bit 3 of address 5 is 0, pending bit 7 is set and source 7 competes with the priority in bits [14:12] of address 1.
- R9: While bit 3 of address 5 is 1, `ext_flag_o` equals the OR of the flag bits and pending bit 7 stays 0.
- R10: `core_req_o` and `core_src_o` update on the clock edge after a change of pending state, not earlier.
- R11: Source n's priority sits at bits [4k+2:4k] of address n/4, where k = n mod 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_i | input | 1 | Non-maskable request, level |
| irq_i | input | 7 | Ordinary interrupt lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| core_req_o | output | 1 | Request to the core |
| core_src_o | output | 4 | Winning source: 0-7 ordinary, 8 non-maskable |
| ext_flag_o | output | 1 | Flag request routed to an external device |

## Verification
The hardest situation to reach from the ports is a latched edge request that must outlive its input pulse. It then has to survive a clear write of 0 and vanish on a clear write of 1.

The bench switches every line to edge mode and gives one line a single-cycle pulse. It then reads the pending register and the outputs after each clear write. A long deterministic sweep writes pseudo-random priorities, masks and line patterns in level mode. Each result is compared with an arithmetic winner model, which brings out ties, zero priorities and mask boundaries in many combinations.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NIRQ = 7,
  parameter int LW   = 3,
  parameter int DW   = 16,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_i,
  input  logic [NIRQ-1:0] irq_i,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            core_req_o,
  output logic [$clog2(NIRQ+2)-1:0] core_src_o,
  output logic            ext_flag_o
);
  localparam int NS = NIRQ + 1;
  localparam int SW = $clog2(NS + 1);

  logic [LW-1:0]   lvl [NS];
  logic [NIRQ-1:0] mode, irq_q, edge_pend, clr;
  logic [DW-1:0]   flag;
  logic [LW-1:0]   mask;
  logic            route;
  logic [NS-1:0]   pend;
  logic [LW-1:0]   best_lvl;
  logic [SW-1:0]   best_src;

  wire flag_any = |flag;
  wire flag_req = flag_any & ~route;
  assign clr = (bus_we && bus_addr == AW'(3)) ? bus_wdata[NIRQ-1:0] : '0;
  assign pend = {flag_req, (edge_pend & mode) | (irq_i & ~mode)};
  assign ext_flag_o = flag_any & route;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) lvl[i] <= '0;
      mode <= '0; irq_q <= '0; edge_pend <= '0;
      flag <= '0; mask <= '0; route <= 1'b0;
      core_req_o <= 1'b0; core_src_o <= '0;
    end else begin
      irq_q <= irq_i;
      edge_pend <= ((edge_pend & ~clr) | (irq_i & ~irq_q)) & mode;
      if (bus_we) begin
        for (int i = 0; i < NS; i++)
          if (bus_addr == AW'(i / 4)) lvl[i] <= bus_wdata[4*(i%4) +: LW];
        if (bus_addr == AW'(2)) mode <= bus_wdata[NIRQ-1:0];
        if (bus_addr == AW'(4)) flag <= bus_wdata;
        if (bus_addr == AW'(5)) {route, mask} <= bus_wdata[LW:0];
      end
      core_req_o <= nmi_i | (best_lvl > mask);
      core_src_o <= nmi_i ? SW'(NS) : best_src;
    end
  end

  always_comb begin
    best_lvl = '0;
    best_src = '0;
    for (int i = 0; i < NS; i++)
      if (pend[i] && lvl[i] > best_lvl) begin
        best_lvl = lvl[i];
        best_src = SW'(i);
      end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NS; i++)
      if (bus_addr == AW'(i / 4)) bus_rdata[4*(i%4) +: LW] = lvl[i];
    case (bus_addr)
      AW'(2): bus_rdata[NIRQ-1:0] = mode;
      AW'(3): bus_rdata[NS-1:0] = pend;
      AW'(4): bus_rdata = flag;
      AW'(5): bus_rdata[LW:0] = {route, mask};
      default: ;
    endcase
  end

  a_r2_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_i |=> (core_req_o && core_src_o == SW'(NS)));

  a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_i && best_lvl <= mask) |=> !core_req_o);

  a_r4_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(edge_pend) & ~$past(clr) & $past(mode) & mode) & ~edge_pend) == '0));

  a_r8_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req_o && core_src_o == SW'(NIRQ)) |-> $past(flag_req));

  a_r10_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_req_o) |-> ($past(nmi_i) || $past(best_lvl) > $past(mask)));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic clk = 0, rst_n = 0, nmi = 0, we = 0;
  logic [6:0] irq = '0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic req, ext;
  logic [3:0] src;
  int nvec = 0, nbad = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5679;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (.clk(clk), .rst_n(rst_n), .nmi_i(nmi), .irq_i(irq),
    .bus_we(we), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .core_req_o(req), .core_src_o(src), .ext_flag_o(ext));

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  function automatic logic [4:0] model(logic [23:0] lv, logic [7:0] p, logic [2:0] m, logic n);
    logic [2:0] bl = 0; logic [3:0] bs = 0;
    for (int i = 0; i < 8; i++)
      if (p[i] && lv[3*i +: 3] > bl) begin bl = lv[3*i +: 3]; bs = 4'(i); end
    if (n) return {1'b1, 4'd8};
    return {bl > m, bs};
  endfunction

  function automatic logic [31:0] nxt(logic [31:0] s);
    s ^= s << 13; s ^= s >> 17; s ^= s << 5;
    return s;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] d;
    logic [23:0] lv;
    logic [2:0] m;
    logic [4:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req", {15'd0, req}, 16'd0);
    chk("R1 ext", {15'd0, ext}, 16'd0);
    chk("R1 src", {12'd0, src}, 16'd0);
    for (int a = 0; a < 6; a++) begin rd(3'(a), d); chk("R1 reg", d, 16'd0); end

    // R2 NMI overrides mask
    wr(3'd5, 16'h0007);
    nmi = 1;
    @(negedge clk);
    chk("R2 req", {15'd0, req}, 16'd1);
    chk("R2 src", {12'd0, src}, 16'd8);
    nmi = 0;
    wr(3'd5, 16'h0000);

    // R10 latency and R11 layout
    wr(3'd0, 16'h0003);
    rd(3'd0, d); chk("R11 readback", d, 16'h0003);
    irq = 7'h01;
    #0.5 chk("R10 before edge", {15'd0, req}, 16'd0);
    @(negedge clk);
    chk("R10 after edge", {11'd0, req, src}, 16'h0010);
    irq = '0;

    // R5 R6 R7 R11 sweep in level mode
    for (int it = 0; it < 3000; it++) begin
      seed = nxt(seed); lv[11:0] = seed[11:0];
      seed = nxt(seed); lv[20:12] = seed[8:0]; lv[23:21] = 3'd0;
      m = seed[15:13];
      wr(3'd0, {1'b0, lv[11:9], 1'b0, lv[8:6], 1'b0, lv[5:3], 1'b0, lv[2:0]});
      wr(3'd1, {4'b0, 1'b0, lv[20:18], 1'b0, lv[17:15], 1'b0, lv[14:12]});
      wr(3'd5, {13'd0, m});
      irq = seed[26:20];
      @(negedge clk);
      e = model(lv, {1'b0, irq}, m, 1'b0);
      chk("R6/R7 req", {15'd0, req}, {15'd0, e[4]});
      if (e[4]) chk("R5/R6 src", {12'd0, src}, {12'd0, e[3:0]});
    end
    irq = '0;

    // R3 level pending cannot be cleared
    wr(3'd0, 16'h0040); wr(3'd5, 16'h0000);
    irq = 7'h02;
    @(negedge clk);
    wr(3'd3, 16'h0002);
    rd(3'd3, d); chk("R3 pend", d, 16'h0002);
    chk("R3 src", {11'd0, req, src}, 16'h0011);
    irq = '0;
    @(negedge clk);
    rd(3'd3, d); chk("R3 follows low", d, 16'h0000);

    // R4 edge sticky
    wr(3'd0, 16'h0500); wr(3'd2, 16'h007f);
    irq = 7'h04; @(negedge clk); irq = '0; @(negedge clk);
    rd(3'd3, d); chk("R4 latched", d, 16'h0004);
    chk("R4 src", {11'd0, req, src}, 16'h0012);
    wr(3'd3, 16'h0000);
    rd(3'd3, d); chk("R4 clear0 no effect", d, 16'h0004);
    wr(3'd3, 16'h0004);
    rd(3'd3, d); chk("R4 cleared", d, 16'h0000);
    @(negedge clk);
    chk("R4 req drop", {15'd0, req}, 16'd0);
    wr(3'd2, 16'h0000);

    // R8 flag to core
    wr(3'd1, 16'h5000); wr(3'd4, 16'h8000);
    rd(3'd4, d); chk("R8 readback", d, 16'h8000);
    rd(3'd3, d); chk("R8 pend7", d, 16'h0080);
    @(negedge clk);
    chk("R8 src", {11'd0, req, src}, 16'h0017);
    chk("R8 ext low", {15'd0, ext}, 16'd0);

    // R9 flag to external pin
    wr(3'd5, 16'h0008);
    rd(3'd3, d); chk("R9 pend7 off", d, 16'h0000);
    chk("R9 ext", {15'd0, ext}, 16'd1);
    @(negedge clk);
    chk("R9 core quiet", {15'd0, req}, 16'd0);
    wr(3'd4, 16'h0000);
    chk("R9 ext off", {15'd0, ext}, 16'd0);

    done = 1;
    finish_run();
  end
endmodule